// File: doc/BRIEF.md
# Synchronized Measurement Gate Controller

This block runs one gated measurement with two counter banks: a gate bank, which sets how long the gate stays open, and a count bank, which counts events while the gate is open. Both clock sources reach the block as one-cycle tick enables in a common clock domain: `refTick` from the timebase and `sigTick` from the signal under test. A mode input picks which tick drives which bank. In frequency mode the gate bank advances on the timebase and the count bank on the signal. In period mode the roles are swapped. Software then gets either events per fixed time or timebase ticks per fixed number of signal periods.

Two state flip-flops, advanced only on gate ticks, form the synchronizer. While `start` is low the controller is idle. The run flop is cleared, the arm flop is set, the gate bank takes the preset value, the count bank is cleared and the mode is captured. After `start` rises, the run flop sets on the next gate tick and the gate opens. The gate bank flags its terminal count 256 ticks early. On the first gate tick after that flag appears, the arm flop clears and the gate closes. For a gate of N ticks the preset is therefore 2^W − (N + 255). `done` then stays high until `start` drops, and dropping `start` also re-arms the controller.

Top module: `meas_gate_top`

## Requirements
- R1: When `modeSel` is 0 (frequency mode), the gate bank advances on `refTick` and the count bank on `sigTick`. A finished measurement reads N·Tref/Tsig on `countOut` when the signal tick period divides the timebase tick period.
- R2: When `modeSel` is 1 (period mode), the gate bank advances on `sigTick` and the count bank on `refTick`. A finished measurement reads N·Tsig/Tref.
- R3: While `start` is low, `gateOpen` and `done` are low at the next clock, `countOut` is zero, and the gate bank reloads from `gatePreset`. `gateOpen` is high only in a cycle that follows a cycle with `start` high.
- R4: After `start` rises, `gateOpen` stays low until the first gate tick, and it rises only after a gate tick.
- R5: With `gatePreset` = 2^W − (N + 255) and N ≥ 2, `gateOpen` stays high for exactly N gate ticks. The early terminal count is the state in which the top W−8 bits of the gate bank are all ones.
- R6: The count bank advances only on cycles in which the gate is open. Once the gate has closed, `countOut` holds its value while `start` stays high. The count bank wraps modulo 2^W.
- R7: `done` rises on the cycle after the gate closes, stays high while `start` is high, and clears once `start` is low.
- R8: `modeSel` is captured only while `start` is low. A change of `modeSel` during a measurement has no effect on it.
- R9: `gateOpen` and `done` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | One-cycle pulse per timebase period |
| sigTick | input | 1 | One-cycle pulse per period of the signal under test |
| modeSel | input | 1 | 0 = frequency mode, 1 = period mode |
| start | input | 1 | High arms and holds a measurement; low returns to idle |
| gatePreset | input | W | Gate bank preset, 2^W − (N + 255) |
| gateOpen | output | 1 | Common count enable of both banks |
| done | output | 1 | Gate has closed; measurement result valid |
| countOut | output | W | Count bank value |

## Verification
The bench covers several corner cases:
- The shortest legal gate (N = 2). A design that placed the early terminal count off by one would give a gate one tick too long or too short, or no gate at all.
- A timebase tick every 50 cycles with `start` raised just after a tick. A design that opened the gate on `start` itself, rather than on the next gate tick, would show `gateOpen` high far too early and read a count that is too large.
- A `modeSel` toggle partway through a gate. A design that re-steered the clocks then would return a count and a gate length matching neither mode.
- After `done`, the bench lets the count tick run on and checks that `countOut` holds. It then drops `start` and checks that `done` and the count clear, catching banks that keep counting or flags that stick.

// File: rtl/meas_gate_pkg.sv
package meas_gate_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadBanks;   // idle: reload gate bank, clear count bank
    logic countEn;     // common count enable (gate open)
    logic periodMode;  // 1: gate bank on signal, count bank on reference
  } gate_strobe_t;

endpackage

// File: rtl/meas_gate_datapath.sv
module meas_gate_datapath
  import meas_gate_pkg::*;
#(
  parameter int W          = 24,
  parameter int EARLY_BITS = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         refTick,
  input  logic         sigTick,
  input  logic [W-1:0] gatePreset,
  input  gate_strobe_t strobe,
  output logic         gateTick,
  output logic         nearEnd,
  output logic [W-1:0] countOut
);

  localparam int HIGH_W = W - EARLY_BITS;

  logic [W-1:0] gateBank;
  logic [W-1:0] countBank;
  logic         countTick;

  // Clock steering by mode
  always_comb begin
    if (strobe.periodMode) begin
      gateTick  = sigTick;
      countTick = refTick;
    end else begin
      gateTick  = refTick;
      countTick = sigTick;
    end
  end

  // Early terminal count: upper HIGH_W bits all ones
  assign nearEnd = &gateBank[W-1 -: HIGH_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gateBank  <= '0;
      countBank <= '0;
    end else if (strobe.loadBanks) begin
      gateBank  <= gatePreset;
      countBank <= '0;
    end else begin
      if (strobe.countEn && gateTick)  gateBank  <= gateBank + 1'b1;
      if (strobe.countEn && countTick) countBank <= countBank + 1'b1;
    end
  end

  assign countOut = countBank;

endmodule

// File: rtl/meas_gate_control.sv
module meas_gate_control
  import meas_gate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         modeSel,
  input  logic         gateTick,
  input  logic         nearEnd,
  output gate_strobe_t strobe,
  output logic         done
);

  logic runQ;     // first flop: held clear when idle
  logic armQ;     // second flop: held set when idle
  logic periodQ;  // mode, captured only while idle

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      armQ    <= 1'b1;
      periodQ <= 1'b0;
    end else if (!start) begin
      runQ    <= 1'b0;
      armQ    <= 1'b1;
      periodQ <= modeSel;
    end else if (gateTick) begin
      if (armQ) runQ <= 1'b1;
      armQ <= !nearEnd;
    end
  end

  always_comb begin
    strobe.loadBanks  = !start;
    strobe.countEn    = runQ && armQ;
    strobe.periodMode = periodQ;
  end

  assign done = runQ && !armQ;

endmodule

// File: rtl/meas_gate_top.sv
module meas_gate_top
  import meas_gate_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         refTick,
  input  logic         sigTick,
  input  logic         modeSel,
  input  logic         start,
  input  logic [W-1:0] gatePreset,
  output logic         gateOpen,
  output logic         done,
  output logic [W-1:0] countOut
);

  gate_strobe_t strobe;
  logic         gateTick;
  logic         nearEnd;
  logic         periodQ;

  meas_gate_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .modeSel  (modeSel),
    .gateTick (gateTick),
    .nearEnd  (nearEnd),
    .strobe   (strobe),
    .done     (done)
  );

  meas_gate_datapath #(.W(W), .EARLY_BITS(8)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .refTick    (refTick),
    .sigTick    (sigTick),
    .gatePreset (gatePreset),
    .strobe     (strobe),
    .gateTick   (gateTick),
    .nearEnd    (nearEnd),
    .countOut   (countOut)
  );

  assign gateOpen = strobe.countEn;
  assign periodQ  = strobe.periodMode;

endmodule

// File: rtl/meas_gate_chk.sv
module meas_gate_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         refTick,
  input logic         sigTick,
  input logic         periodQ,
  input logic         gateOpen,
  input logic         done,
  input logic [W-1:0] countOut
);

  // R3
  open_needs_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    gateOpen |-> $past(start));

  // R4
  open_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOpen) |-> $past(periodQ ? sigTick : refTick));

  // R6
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && $past(start) && $past(!gateOpen)) |-> $stable(countOut));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> done);

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && $past(start)) |-> $stable(periodQ));

  // R9
  open_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(gateOpen && done));

endmodule

bind meas_gate_top meas_gate_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .refTick  (refTick),
  .sigTick  (sigTick),
  .periodQ  (periodQ),
  .gateOpen (gateOpen),
  .done     (done),
  .countOut (countOut)
);

// File: tb/tb_meas_gate_top.sv
`timescale 1ns/1ps
module tb_meas_gate_top;

  localparam int W = 24;

  typedef struct {
    int    count;
    int    openCycles;
    string req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         refTick = 1'b0;
  logic         sigTick = 1'b0;
  logic         modeSel = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] gatePreset = '0;
  logic         gateOpen;
  logic         done;
  logic [W-1:0] countOut;

  int checks = 0;
  int errors = 0;
  int refPer = 1;
  int sigPer = 1;
  int refCnt = 0;
  int sigCnt = 0;
  int openCnt = 0;
  int seenDone = 0;
  logic prevDone = 1'b0;
  exp_t expQ[$];

  always #2.5 clk = ~clk;

  meas_gate_top #(.W(W)) dut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .sigTick(sigTick),
    .modeSel(modeSel), .start(start), .gatePreset(gatePreset),
    .gateOpen(gateOpen), .done(done), .countOut(countOut)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Tick generators, driven away from the active edge
  always @(negedge clk) begin
    refTick <= (refCnt == 0);
    sigTick <= (sigCnt == 0);
    refCnt  <= (refCnt >= refPer - 1) ? 0 : refCnt + 1;
    sigCnt  <= (sigCnt >= sigPer - 1) ? 0 : sigCnt + 1;
  end

  // Monitor: counts open cycles, compares on rise of done
  initial begin
    forever begin
      @(posedge clk); #1;
      if (!start) openCnt = 0;
      else if (gateOpen) openCnt++;
      if (done && !prevDone) begin
        if (expQ.size() == 0) begin
          chk("R7", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          chk(e.req, "count", int'(countOut), e.count);
          chk("R5", "gate cycles", openCnt, e.openCycles);
        end
        seenDone++;
      end
      prevDone = done;
    end
  end

  task automatic runMeas(input logic isPeriod, input int n, input int rp, input int sp,
                         input int flipAfter, input string req);
    exp_t e;
    int gp;
    int cp;
    int held;
    int waitN;
    @(negedge clk);
    start = 1'b0;
    modeSel = isPeriod;
    refPer = rp; sigPer = sp; refCnt = 0; sigCnt = 0;
    gatePreset = W'((1 << W) - (n + 255));
    repeat (4) @(negedge clk);
    gp = isPeriod ? sp : rp;
    cp = isPeriod ? rp : sp;
    e.count = n * gp / cp;
    e.openCycles = n * gp;
    e.req = req;
    expQ.push_back(e);
    if (rp >= 20) begin
      // wait until a gate tick has just been used, then start
      do begin @(posedge clk); #1; end while (!refTick);
      @(negedge clk); start = 1'b1;
      repeat (10) @(posedge clk);
      #1 chk("R4", "gate opened before gate tick", int'(gateOpen), 0);
    end else begin
      start = 1'b1;
    end
    if (flipAfter > 0) begin
      repeat (flipAfter) @(negedge clk);
      modeSel = !modeSel;
    end
    waitN = seenDone;
    while (seenDone == waitN) @(posedge clk);
    #1 chk("R9", "gateOpen with done", int'(gateOpen), 0);
    held = int'(countOut);
    repeat (12) @(posedge clk);
    #1 chk("R6", "count held after close", int'(countOut), held);
    chk("R7", "done held while start", int'(done), 1);
    @(negedge clk); start = 1'b0;
    @(posedge clk); #1;
    chk("R7", "done cleared", int'(done), 0);
    chk("R3", "count cleared when idle", int'(countOut), 0);
    chk("R3", "gate closed when idle", int'(gateOpen), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk("R3", "reset gateOpen", int'(gateOpen), 0);
    chk("R3", "reset done", int'(done), 0);
    chk("R3", "reset count", int'(countOut), 0);

    runMeas(1'b0, 2,   1, 1, 0, "R1");   // shortest gate
    runMeas(1'b0, 300, 4, 1, 0, "R1");
    runMeas(1'b0, 50,  6, 2, 0, "R1");
    runMeas(1'b1, 40,  1, 5, 0, "R2");
    runMeas(1'b1, 2,   1, 3, 0, "R2");
    runMeas(1'b0, 20,  4, 1, 10, "R8");  // mode toggled mid-gate
    runMeas(1'b0, 2,  50, 1, 0, "R4");   // sparse gate ticks

    chk("R7", "all results seen", expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule